// File: doc/BRIEF.md
# Per-Trigger Disable Gating and Veto Scalers

This block serves a single specific-trigger channel. Fourteen disable sources arrive each crossing: front-end busy, prescaler, run control, auto-disable, two individual gated disables, four internal global disables and four external global disables. A per-trigger allow mask selects which of them act on this trigger. The trigger is enabled on a crossing only when no allowed source is active. Every allowed and active source is also counted, so the share of crossings that each source took from this trigger can be measured.

Each source has its own wrapping scaler that advances on the crossing strobe. Two more scalers count crossings with the exposed condition and with the DAQ-enable condition. A three-stage shift on the crossing strobe holds the previous, current and next view of the exposed and DAQ-enable conditions. The gated disable mask is delayed to line up with the current stage. A common monitor capture pulse copies all scalers and the assembled 32-bit status word into snapshot registers in the same cycle. A host reads those snapshot registers through logic outside this block.

Top module: `trig_disable_mon`

## Requirements
- R1: While reset is asserted, all snapshot outputs read zero, and the live scalers and shift stages are cleared.
- R2: `trigEnable` is 1 exactly when no source that is both active in `disableSrc` and allowed in `allowMask` exists (combinational, same cycle).
- R3: A source whose `allowMask` bit is 0 has no effect: it neither clears `trigEnable` nor advances its veto scaler.
- R4: On each clock with `xingStb` high, veto scaler i advances by one when `disableSrc[i] & allowMask[i]`. Without `xingStb`, no scaler changes. Source index order is front-end busy (0), prescaler (1), run control (2), auto-disable (3), individual 0 and 1 (4, 5), internal global 0..3 (6..9) and external global 0..3 (10..13). Scaler i occupies `vetoSnap[i*CNT_W +: CNT_W]`.
- R5: The exposed and DAQ-enable scalers advance by one on each `xingStb` clock on which `exposedIn`, respectively `daqEnIn`, is high.
- R6: Status bits 2, 3 and 4 hold `exposedIn` as sampled on the third-latest, second-latest and latest `xingStb` (previous, current, next). Bits 15, 16 and 17 hold `daqEnIn` in the same way.
- R7: Status bits 18..31 hold the gated disable mask sampled on the second-latest `xingStb` (the current crossing), with source i at bit 18+i. Bits 0, 1 and 5..14 read 0.
- R8: A clock with `capturePulse` high updates every snapshot output at once with the values the live state had before that edge, including an edge that also carries `xingStb`. Without the pulse, the snapshots hold.
- R9: Every scaler is `CNT_W` bits wide (default 32) and wraps from all-ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xingStb | input | 1 | One-clock strobe per beam crossing |
| capturePulse | input | 1 | Common monitor capture pulse |
| disableSrc | input | 14 | Disable sources, index order as in R4 |
| allowMask | input | 14 | Per-trigger allow bit for each source |
| exposedIn | input | 1 | Exposed condition for this crossing |
| daqEnIn | input | 1 | DAQ-enable condition for this crossing |
| trigEnable | output | 1 | Trigger enable for this crossing |
| statusSnap | output | 32 | Captured status word |
| vetoSnap | output | 14*CNT_W | Captured veto scalers, source i at slice i |
| exposedSnap | output | CNT_W | Captured exposed scaler |
| daqSnap | output | CNT_W | Captured DAQ-enable scaler |

## Verification
A gating fault shows at `trigEnable` in the same cycle it occurs. A fault in a live scaler or a shift stage stays hidden until the next capture pulse. After that pulse it appears one clock later in the snapshot outputs, where a miscount shows up as a wrong scaler value and a misaligned stage shows up as a wrong status bit. The bench therefore captures after every distinct stimulus pattern, including a capture on a strobe edge and a capture after the counter wraps. On every other clock it checks that the snapshots hold their value.

// File: rtl/trig_mon_pkg.sv
package trig_mon_pkg;
  localparam int NUM_SRC     = 14;
  localparam int STATUS_W    = 32;
  localparam int ST_EXP_LSB  = 2;
  localparam int ST_DAQ_LSB  = 15;
  localparam int ST_MASK_LSB = 18;
  localparam int NUM_COND    = 2;

  // source indices; the status layout depends on this order
  localparam int SRC_FEBUSY   = 0;
  localparam int SRC_PRESCALE = 1;
  localparam int SRC_RUNCTL   = 2;
  localparam int SRC_AUTO     = 3;
  localparam int SRC_INDIV0   = 4;
  localparam int SRC_INDIV1   = 5;
  localparam int SRC_INTG0    = 6;
  localparam int SRC_EXTG0    = 10;

  typedef struct packed {
    logic advance;
    logic capture;
  } monStrobe_t;

  typedef struct packed {
    logic prev;
    logic cur;
    logic next;
  } xingWin_t;
endpackage

// File: rtl/trig_mon_scaler.sv
module trig_mon_scaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             hit,
  input  logic             capture,
  output logic [CNT_W-1:0] snap
);
  logic [CNT_W-1:0] live;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live <= '0;
      snap <= '0;
    end else begin
      if (advance && hit) live <= live + CNT_W'(1);
      if (capture) snap <= live;
    end
  end
endmodule

// File: rtl/trig_mon_ctrl.sv
module trig_mon_ctrl
  import trig_mon_pkg::*;
(
  input  logic       xingStb,
  input  logic       capturePulse,
  output monStrobe_t strobes
);
  always_comb begin
    strobes.advance = xingStb;
    strobes.capture = capturePulse;
  end
endmodule

// File: rtl/trig_mon_datapath.sv
module trig_mon_datapath
  import trig_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  monStrobe_t               strobes,
  input  logic [NUM_SRC-1:0]       disableSrc,
  input  logic [NUM_SRC-1:0]       allowMask,
  input  logic                     exposedIn,
  input  logic                     daqEnIn,
  output logic                     trigEnable,
  output logic [STATUS_W-1:0]      statusSnap,
  output logic [NUM_SRC*CNT_W-1:0] vetoSnap,
  output logic [CNT_W-1:0]         exposedSnap,
  output logic [CNT_W-1:0]         daqSnap
);
  logic [NUM_SRC-1:0]  gated;
  logic [NUM_SRC-1:0]  maskNext, maskCur;
  logic [NUM_COND-1:0] condIn;
  xingWin_t            win [NUM_COND];
  logic [STATUS_W-1:0] liveStatus;

  assign gated      = disableSrc & allowMask;
  assign trigEnable = ~|gated;
  assign condIn     = {daqEnIn, exposedIn};

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : gVeto
      trig_mon_scaler #(.CNT_W(CNT_W)) uVeto (
        .clk(clk), .rstN(rstN), .advance(strobes.advance), .hit(gated[g]),
        .capture(strobes.capture), .snap(vetoSnap[g*CNT_W +: CNT_W])
      );
    end
    for (g = 0; g < NUM_COND; g++) begin : gWin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) win[g] <= '0;
        else if (strobes.advance) win[g] <= {win[g].cur, win[g].next, condIn[g]};
      end
    end
  endgenerate

  trig_mon_scaler #(.CNT_W(CNT_W)) uExposed (
    .clk(clk), .rstN(rstN), .advance(strobes.advance), .hit(exposedIn),
    .capture(strobes.capture), .snap(exposedSnap)
  );
  trig_mon_scaler #(.CNT_W(CNT_W)) uDaq (
    .clk(clk), .rstN(rstN), .advance(strobes.advance), .hit(daqEnIn),
    .capture(strobes.capture), .snap(daqSnap)
  );

  // gated mask delayed to the middle (current) stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskNext <= '0;
      maskCur  <= '0;
    end else if (strobes.advance) begin
      maskNext <= gated;
      maskCur  <= maskNext;
    end
  end

  always_comb begin
    liveStatus = '0;
    liveStatus[ST_EXP_LSB +: 3]        = {win[0].next, win[0].cur, win[0].prev};
    liveStatus[ST_DAQ_LSB +: 3]        = {win[1].next, win[1].cur, win[1].prev};
    liveStatus[ST_MASK_LSB +: NUM_SRC] = maskCur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusSnap <= '0;
    else if (strobes.capture) statusSnap <= liveStatus;
  end
endmodule

// File: rtl/trig_disable_mon.sv
module trig_disable_mon
  import trig_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     xingStb,
  input  logic                     capturePulse,
  input  logic [NUM_SRC-1:0]       disableSrc,
  input  logic [NUM_SRC-1:0]       allowMask,
  input  logic                     exposedIn,
  input  logic                     daqEnIn,
  output logic                     trigEnable,
  output logic [STATUS_W-1:0]      statusSnap,
  output logic [NUM_SRC*CNT_W-1:0] vetoSnap,
  output logic [CNT_W-1:0]         exposedSnap,
  output logic [CNT_W-1:0]         daqSnap
);
  monStrobe_t strobes;

  trig_mon_ctrl uCtrl (
    .xingStb(xingStb), .capturePulse(capturePulse), .strobes(strobes)
  );

  trig_mon_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .disableSrc(disableSrc), .allowMask(allowMask),
    .exposedIn(exposedIn), .daqEnIn(daqEnIn),
    .trigEnable(trigEnable), .statusSnap(statusSnap), .vetoSnap(vetoSnap),
    .exposedSnap(exposedSnap), .daqSnap(daqSnap)
  );
endmodule

// File: rtl/trig_disable_mon_chk.sv
module trig_disable_mon_chk
  import trig_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     capturePulse,
  input logic [NUM_SRC-1:0]       disableSrc,
  input logic [NUM_SRC-1:0]       allowMask,
  input logic                     trigEnable,
  input logic [STATUS_W-1:0]      statusSnap,
  input logic [NUM_SRC*CNT_W-1:0] vetoSnap,
  input logic [CNT_W-1:0]         exposedSnap,
  input logic [CNT_W-1:0]         daqSnap
);
  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (statusSnap == '0 && vetoSnap == '0 && exposedSnap == '0 && daqSnap == '0); // R1
    end
  end

  AST_FEBUSY_VETO: assert property (@(posedge clk) disable iff (!rstN)
    (disableSrc[SRC_FEBUSY] && allowMask[SRC_FEBUSY]) |-> !trigEnable); // R2

  AST_NOMASK_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (allowMask == '0) |-> trigEnable); // R3

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !capturePulse |=> ($stable(statusSnap) && $stable(vetoSnap) && $stable(exposedSnap) && $stable(daqSnap))); // R8

  AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (capturePulse && $past(capturePulse)) |=> (CNT_W'(exposedSnap - $past(exposedSnap)) <= CNT_W'(1))); // R5
endmodule

bind trig_disable_mon trig_disable_mon_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .capturePulse(capturePulse),
  .disableSrc(disableSrc), .allowMask(allowMask), .trigEnable(trigEnable),
  .statusSnap(statusSnap), .vetoSnap(vetoSnap),
  .exposedSnap(exposedSnap), .daqSnap(daqSnap)
);

// File: tb/sim_trig_disable_mon.sv
module sim_trig_disable_mon;
  import trig_mon_pkg::*;
  localparam int CW = 6;
  localparam logic [NUM_SRC-1:0] ALL = '1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, xingStb = 1'b0, capturePulse = 1'b0;
  logic [NUM_SRC-1:0] disableSrc = '0, allowMask = '0;
  logic exposedIn = 1'b0, daqEnIn = 1'b0;
  logic trigEnable;
  logic [STATUS_W-1:0] statusSnap;
  logic [NUM_SRC*CW-1:0] vetoSnap;
  logic [CW-1:0] exposedSnap, daqSnap;

  trig_disable_mon #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .xingStb(xingStb), .capturePulse(capturePulse),
    .disableSrc(disableSrc), .allowMask(allowMask), .exposedIn(exposedIn),
    .daqEnIn(daqEnIn), .trigEnable(trigEnable), .statusSnap(statusSnap),
    .vetoSnap(vetoSnap), .exposedSnap(exposedSnap), .daqSnap(daqSnap)
  );

  typedef struct {
    logic [STATUS_W-1:0]   st;
    logic [NUM_SRC*CW-1:0] veto;
    logic [CW-1:0]         ex;
    logic [CW-1:0]         dq;
    string                 tag;
  } item_t;

  item_t sbQ[$];
  item_t lastItem;
  int checks = 0, errors = 0;

  // reference model
  int vCnt[NUM_SRC];
  int eCnt = 0, dCnt = 0;
  logic [2:0] mExp = '0, mDaq = '0;   // [0]=newest (next), [1]=current, [2]=previous
  logic [NUM_SRC-1:0] mMaskN = '0, mMaskC = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic item_t snapModel(input string tag);
    item_t it;
    it.st = '0;
    it.st[2] = mExp[2]; it.st[3] = mExp[1]; it.st[4] = mExp[0];
    it.st[15] = mDaq[2]; it.st[16] = mDaq[1]; it.st[17] = mDaq[0];
    it.st[31:18] = mMaskC;
    for (int i = 0; i < NUM_SRC; i++) it.veto[i*CW +: CW] = CW'(vCnt[i]);
    it.ex = CW'(eCnt);
    it.dq = CW'(dCnt);
    it.tag = tag;
    return it;
  endfunction

  // driver: called just after a falling edge
  task automatic step(input logic [NUM_SRC-1:0] src, input logic [NUM_SRC-1:0] mask,
                      input logic ex, input logic dq, input logic stb, input logic cap,
                      input string tag);
    logic [NUM_SRC-1:0] g;
    disableSrc = src; allowMask = mask; exposedIn = ex; daqEnIn = dq;
    xingStb = stb; capturePulse = cap;
    g = src & mask;
    if (cap) sbQ.push_back(snapModel(tag));
    #1;
    check(trigEnable == ~|g, (|(src & ~mask)) ? "R3" : "R2", "trigEnable",
          128'(trigEnable), 128'(~|g));
    if (stb) begin
      for (int i = 0; i < NUM_SRC; i++) if (g[i]) vCnt[i]++;
      if (ex) eCnt++;
      if (dq) dCnt++;
      mExp = {mExp[1:0], ex};
      mDaq = {mDaq[1:0], dq};
      mMaskC = mMaskN;
      mMaskN = g;
    end
    @(negedge clk);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    lastItem = snapModel("R1");
    forever begin
      bit capSeen;
      item_t it;
      @(posedge clk);
      capSeen = capturePulse && rstN;
      #2;
      if (capSeen) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R8", "unexpected capture", 0, 0);
        end else begin
          it = sbQ.pop_front();
          lastItem = it;
        end
      end
      check(statusSnap == lastItem.st, capSeen ? {lastItem.tag, " R6 R7"} : "R8 R1",
            "statusSnap", 128'(statusSnap), 128'(lastItem.st));
      check(vetoSnap == lastItem.veto, capSeen ? {lastItem.tag, " R4"} : "R8 R1",
            "vetoSnap", 128'(vetoSnap), 128'(lastItem.veto));
      check(exposedSnap == lastItem.ex && daqSnap == lastItem.dq,
            capSeen ? {lastItem.tag, " R5"} : "R8 R1", "exposed/daq snap",
            128'({exposedSnap, daqSnap}), 128'({lastItem.ex, lastItem.dq}));
    end
  end

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", "run timed out", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_SRC; i++) vCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 R4: each source alone, all allowed, with varying conditions
    step('0, ALL, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < NUM_SRC; i++)
      step(NUM_SRC'(1) << i, ALL, i[0], (i % 3) == 0, 1'b1, 1'b0, "R4");
    step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b1, "R4 R6");
    // R6 R7: window pattern exposed 1,0,0 daq 0,1,1, mask at current stage
    step(14'h2001, ALL, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    step(14'h0842, ALL, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    step(14'h0100, ALL, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b1, "R6 R7");
    // R3: disallowed sources neither veto nor count
    step(ALL, '0, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    step(14'h00F0, 14'h3F0F, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    step(14'h3C00, 14'h0C00, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
    step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    // R4: active sources without crossing strobe do not count
    repeat (3) step(ALL, ALL, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    // R8: capture on a strobe edge takes pre-edge values, then back-to-back capture
    step(14'h0005, ALL, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
    step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    // R9: wrap of the narrow bench scalers
    for (int k = 0; k < 70; k++) step(14'h0001, 14'h0001, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    repeat (3) step('0, ALL, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    check(sbQ.size() == 0, "R8", "scoreboard drained", 128'(sbQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule